// File: doc/BRIEF.md
# Banked-Register Accumulator Core

This block is a small 8-bit processor core that runs a program held in its own 64-word code store. Instructions are 9 bits wide. Each fetch runs one instruction, and fetches are addressed by a 6-bit instruction pointer. The datapath has four 8-bit registers, two on the X side and two on the Y side. An ALU always reads one X register and one Y register, chosen by two latched bank bits. The core keeps a carry flag and a zero flag. The instruction set has conditional and unconditional jumps, ALU operations, a masked load-immediate, clear-carry and halt.

The code store is filled through a valid/ready write port. `prog_ready` is always high, so the port never applies back-pressure. A word is stored at the rising edge where `prog_valid` is high, and it can be fetched from the next cycle on. The store is not cleared by reset. The intended use is to hold `rst` high while the program is written, then release `rst`. The core starts at address 0, runs until it halts, and then holds its state. The results are observed on `halted`, `x0_out` and `cycle_count`.

Top module: `bank_acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core resets to this state: not halted, cycle count 0, instruction pointer 0, all registers 0, operation add, both bank bits 0, carry 0 and zero 1. The zero flag is the add of two cleared registers.
- R2: Decode is a priority scheme from the top bit down, applied in this order:
  - bit 8 selects a conditional branch;
  - otherwise bit 7 selects an ALU operation;
  - otherwise bit 6 selects an unconditional jump;
  - otherwise bit 5 is invalid and halts;
  - otherwise bit 4 selects load-immediate;
  - otherwise bits 2:0 decode as 0 = halt, 1 = clear carry, and any other value halts.
- R3: The ALU instruction fields are bit 6 = X bank (register x0 or x1), bit 5 = Y bank (register y0 or y1), bits 4:2 = operation and bits 1:0 = destination index. The registers are indexed 0 = x0, 1 = x1, 2 = y0, 3 = y1. The result is written to the destination. The bank bits and the operation stay latched after the instruction.
- R4: The operation codes are 0 add, 1 xor, 2 and, 3 or, 4 pass X and 5 pass Y. Carry is bit 8 of the 9-bit add sum, and every other operation yields carry 0. Zero is set when the 8-bit result is 0.
- R5: After every register write, carry and zero are recomputed. The recompute uses the latched operation and bank bits and the register contents after the write. This applies to ALU writes, including a write to one of the ALU's own operands, and to load-immediate writes.
- R6: For a conditional branch, bit 7 is an invert bit, bit 6 selects the flag (1 = zero, 0 = carry) and bits 5:0 are the target. The branch is taken when the selected flag differs from the invert bit.
- R7: An unconditional jump loads bits 5:0 of the instruction into the instruction pointer.
- R8: For load-immediate, bits 3:0 are a write mask over registers 0 to 3. The low 8 bits of the next code word are written to every selected register in a second cycle. That second cycle does not increment the cycle count, and execution resumes after the data word.
- R9: Clear carry sets carry to 0 and leaves zero unchanged.
- R10: Halt, an invalid word, or an ALU operation code 6 or 7 all set `halted`. An ALU operation code 6 or 7 writes no register. From then until reset, the instruction pointer, registers, flags and cycle count are frozen.
- R11: `cycle_count` increments by one for every instruction fetched while not halted. This includes the fetch of the instruction that halts.
- R12: `prog_ready` is always 1, and a word offered with `prog_valid` is stored at that edge and becomes visible to fetches from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_valid | input | 1 | Code-store write request |
| prog_ready | output | 1 | Code-store write accept, always 1 |
| prog_addr | input | 6 | Code-store write address |
| prog_data | input | 9 | Code-store write word |
| halted | output | 1 | Core has stopped |
| x0_out | output | DATA_W | Contents of register x0 |
| cycle_count | output | CYC_W | Instructions fetched since reset |

## Verification
The bench sweeps every ALU operation over pairs of operands that include carry-out, zero results and all-ones values. Each result is read back through all four flag branches, so swapped flag tests, an inverted invert bit, or a carry left set by the logical operations would send execution down the wrong path and change `x0_out` and the count. Directed programs cover the following cases:
- The recompute after an ALU writes one of its own operands. A core that took its flags from the pre-write result would take a carry branch it should skip.
- A load-immediate into a register selected by a latched pass-X operation. A core that ignored that write for the flags would fall through.
- Clear-carry, which must leave zero set.
- Decode priority on words with several high bits set. A core that let a lower bit win would halt after the wrong number of fetches.
- Invalid ALU codes, which must halt with x0 untouched.
- The immediate cycle, which must not be counted. A core that counted it would report one extra fetch.

// File: rtl/bac_pkg.sv
package bac_pkg;

  localparam int unsigned CODE_AW    = 6;
  localparam int unsigned CODE_DEPTH = 1 << CODE_AW;
  localparam int unsigned INSN_W     = 9;
  localparam int unsigned NREG       = 4;
  localparam int unsigned RIDX_W     = $clog2(NREG);

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_XOR   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_PASSX = 3'd4,
    OP_PASSY = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    K_CBR  = 3'd0,
    K_ALU  = 3'd1,
    K_JMP  = 3'd2,
    K_LDI  = 3'd3,
    K_CLC  = 3'd4,
    K_STOP = 3'd5
  } insn_kind_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_IMM   = 1'b1
  } phase_e;

  typedef struct packed {
    insn_kind_e          kind;
    logic                inv;
    logic                use_zero;
    logic [CODE_AW-1:0]  target;
    logic                bank_x;
    logic                bank_y;
    alu_op_e             op;
    logic [RIDX_W-1:0]   dst;
    logic [NREG-1:0]     mask;
  } dec_t;

endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              d
);

  always_comb begin
    d          = '0;
    d.inv      = word[7];
    d.use_zero = word[6];
    d.target   = word[CODE_AW-1:0];
    d.bank_x   = word[6];
    d.bank_y   = word[5];
    d.op       = alu_op_e'(word[4:2]);
    d.dst      = word[RIDX_W-1:0];
    d.mask     = word[NREG-1:0];
    if (word[8]) begin
      d.kind = K_CBR;
    end else if (word[7]) begin
      d.kind = (word[4:2] > 3'd5) ? K_STOP : K_ALU;
    end else if (word[6]) begin
      d.kind = K_JMP;
    end else if (word[5]) begin
      d.kind = K_STOP;
    end else if (word[4]) begin
      d.kind = K_LDI;
    end else if (word[2:0] == 3'd1) begin
      d.kind = K_CLC;
    end else begin
      d.kind = K_STOP;
    end
  end

endmodule

// File: rtl/bac_alu.sv
module bac_alu
  import bac_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         zero
);

  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, x} + {1'b0, y};
    carry = 1'b0;
    unique case (op)
      OP_ADD: begin
        res   = sum[W-1:0];
        carry = sum[W];
      end
      OP_XOR:   res = x ^ y;
      OP_AND:   res = x & y;
      OP_OR:    res = x | y;
      OP_PASSX: res = x;
      OP_PASSY: res = y;
      default:  res = '0;
    endcase
    zero = (res == '0);
  end

endmodule

// File: rtl/bac_regfile.sv
module bac_regfile
  import bac_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREG-1:0]           we,
  input  logic [W-1:0]              wd,
  output logic [NREG-1:0][W-1:0]    q,
  output logic [NREG-1:0][W-1:0]    q_next
);

  logic [W-1:0] r [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign q[i]      = r[i];
    assign q_next[i] = we[i] ? wd : r[i];
    always_ff @(posedge clk) begin
      if (rst) r[i] <= '0;
      else     r[i] <= q_next[i];
    end
  end

endmodule

// File: rtl/bank_acc_core.sv
module bank_acc_core
  import bac_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CYC_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prog_valid,
  output logic                prog_ready,
  input  logic [CODE_AW-1:0]  prog_addr,
  input  logic [INSN_W-1:0]   prog_data,
  output logic                halted,
  output logic [DATA_W-1:0]   x0_out,
  output logic [CYC_W-1:0]    cycle_count
);

  // code store
  logic [INSN_W-1:0] code_mem [CODE_DEPTH];

  assign prog_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (prog_valid && prog_ready) code_mem[prog_addr] <= prog_data;
  end

  // architectural state
  logic [CODE_AW-1:0] ip_q, ip_n;
  phase_e             ph_q, ph_n;
  logic               halt_q, halt_n;
  logic [CYC_W-1:0]   cyc_q, cyc_n;
  logic               bx_q, bx_n, by_q, by_n;
  alu_op_e            op_q, op_n;
  logic [NREG-1:0]    lmask_q, lmask_n;
  logic               carry_q, carry_n, zero_q, zero_n;
  logic               clc_req;
  logic               in_imm;

  logic [INSN_W-1:0]          word;
  dec_t                       dec;
  logic [NREG-1:0]            we;
  logic [DATA_W-1:0]          wd;
  logic [NREG-1:0][DATA_W-1:0] regs, regs_nx;

  logic [DATA_W-1:0] exe_res, flg_res;
  logic              exe_c, exe_z, flg_c, flg_z;
  logic              flag_pick;

  assign word   = code_mem[ip_q];
  assign in_imm = (ph_q == PH_IMM);

  bac_decode u_dec (
    .word (word),
    .d    (dec)
  );

  bac_regfile #(.W(DATA_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .wd     (wd),
    .q      (regs),
    .q_next (regs_nx)
  );

  // execute ALU: operands chosen by the instruction's own bank fields
  bac_alu #(.W(DATA_W)) u_alu_exe (
    .x     (regs[{1'b0, dec.bank_x}]),
    .y     (regs[{1'b1, dec.bank_y}]),
    .op    (dec.op),
    .res   (exe_res),
    .carry (exe_c),
    .zero  (exe_z)
  );

  // flag ALU: re-evaluates with post-write contents and latched selections
  bac_alu #(.W(DATA_W)) u_alu_flg (
    .x     (regs_nx[{1'b0, bx_n}]),
    .y     (regs_nx[{1'b1, by_n}]),
    .op    (op_n),
    .res   (flg_res),
    .carry (flg_c),
    .zero  (flg_z)
  );

  assign flag_pick = dec.use_zero ? zero_q : carry_q;
  assign wd        = in_imm ? word[DATA_W-1:0] : exe_res;

  always_comb begin
    ip_n    = ip_q;
    ph_n    = ph_q;
    halt_n  = halt_q;
    cyc_n   = cyc_q;
    bx_n    = bx_q;
    by_n    = by_q;
    op_n    = op_q;
    lmask_n = lmask_q;
    we      = '0;
    clc_req = 1'b0;
    if (in_imm) begin
      we   = lmask_q;
      ip_n = ip_q + 1'b1;
      ph_n = PH_FETCH;
    end else if (!halt_q) begin
      cyc_n = cyc_q + 1'b1;
      ip_n  = ip_q + 1'b1;
      unique case (dec.kind)
        K_CBR: begin
          if (flag_pick ^ dec.inv) ip_n = dec.target;
        end
        K_ALU: begin
          bx_n = dec.bank_x;
          by_n = dec.bank_y;
          op_n = dec.op;
          we   = NREG'(1) << dec.dst;
        end
        K_JMP: ip_n = dec.target;
        K_LDI: begin
          lmask_n = dec.mask;
          ph_n    = PH_IMM;
        end
        K_CLC:  clc_req = 1'b1;
        K_STOP: halt_n  = 1'b1;
        default: halt_n = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (|we) begin
      carry_n = flg_c;
      zero_n  = flg_z;
    end else begin
      carry_n = clc_req ? 1'b0 : carry_q;
      zero_n  = zero_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q    <= '0;
      ph_q    <= PH_FETCH;
      halt_q  <= 1'b0;
      cyc_q   <= '0;
      bx_q    <= 1'b0;
      by_q    <= 1'b0;
      op_q    <= OP_ADD;
      lmask_q <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      ip_q    <= ip_n;
      ph_q    <= ph_n;
      halt_q  <= halt_n;
      cyc_q   <= cyc_n;
      bx_q    <= bx_n;
      by_q    <= by_n;
      op_q    <= op_n;
      lmask_q <= lmask_n;
      carry_q <= carry_n;
      zero_q  <= zero_n;
    end
  end

  assign halted      = halt_q;
  assign x0_out      = regs[0];
  assign cycle_count = cyc_q;

endmodule

// File: rtl/bac_chk.sv
module bac_chk
  import bac_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CYC_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               halted,
  input logic [DATA_W-1:0]  x0,
  input logic [CYC_W-1:0]   cycles,
  input logic [CODE_AW-1:0] ip,
  input logic               imm_phase
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cycles == '0 && !halted && ip == '0 && !imm_phase));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(x0) && $stable(ip) && $stable(cycles)));

  // R11
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !imm_phase) |=> (cycles == CYC_W'($past(cycles) + 1'b1)));

  // R8
  imm_not_counted_chk: assert property (@(posedge clk) disable iff (rst)
    imm_phase |=> ($stable(cycles) && !imm_phase));

  // R8
  imm_ip_step_chk: assert property (@(posedge clk) disable iff (rst)
    imm_phase |=> (ip == CODE_AW'($past(ip) + 1'b1)));

endmodule

bind bank_acc_core bac_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halted    (halted),
  .x0        (x0_out),
  .cycles    (cycle_count),
  .ip        (ip_q),
  .imm_phase (in_imm)
);

// File: tb/bank_acc_core_bench.sv
`timescale 1ns/1ps
module bank_acc_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_valid = 1'b0;
  logic       prog_ready;
  logic [5:0] prog_addr = '0;
  logic [8:0] prog_data = '0;
  logic       halted;
  logic [7:0] x0_out;
  logic [15:0] cycle_count;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bank_acc_core u_bank_acc_core (
    .clk         (clk),
    .rst         (rst),
    .prog_valid  (prog_valid),
    .prog_ready  (prog_ready),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .halted      (halted),
    .x0_out      (x0_out),
    .cycle_count (cycle_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // hold reset and start a new program (called at a falling edge)
  task automatic prog_start();
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int a, input int d);
    prog_valid = 1'b1;
    prog_addr  = 6'(a);
    prog_data  = 9'(d);
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic run_prog(input string req, input int ex_x0, input int ex_cyc);
    rst = 1'b0;
    for (int i = 0; i < 300 && !halted; i++) @(negedge clk);
    chk({req, " halted"}, int'(halted), 1);
    chk({req, " x0"}, int'(x0_out), ex_x0);
    chk({req, " cycles"}, int'(cycle_count), ex_cyc);
  endtask

  function automatic int model_res(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 255;
      1: return a ^ b;
      2: return a & b;
      3: return a | b;
      4: return a;
      default: return b;
    endcase
  endfunction

  int vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h0F};
  int bad_words [9] = '{9'h020, 9'h03F, 9'h002, 9'h003, 9'h004, 9'h007, 9'h098, 9'h09C, 9'h0FB};

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    prog_start();
    // R12: port never back-pressures
    chk("R12 ready", int'(prog_ready), 1);

    // R1 reset state, R11 halt fetch counted
    put(0, 9'h000);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 cycles in reset", int'(cycle_count), 0);
    chk("R1 x0 in reset", int'(x0_out), 0);
    run_prog("R1 R11 halt at 0", 0, 1);

    // R1 reset flags: zero=1 -> jz taken
    prog_start();
    put(0, 9'h145); put(1, 9'h011); put(2, 9'h055); put(3, 0); put(5, 0);
    run_prog("R1 R6 jz after reset", 0, 2);
    // carry=0 -> jc not taken
    prog_start();
    put(0, 9'h105); put(1, 9'h011); put(2, 9'h055); put(3, 0); put(5, 0);
    run_prog("R1 R6 jc after reset", 8'h55, 3);

    // R5 R8: ldi x0,y0 = 0x80 recomputes add -> carry; imm cycle uncounted
    prog_start();
    put(0, 9'h015); put(1, 9'h080); put(2, 9'h108); put(3, 9'h011);
    put(4, 9'h011); put(5, 0); put(8, 0);
    run_prog("R5 R8 ldi flags", 8'h80, 3);

    // R9 clear carry keeps zero
    prog_start();
    put(0, 9'h015); put(1, 9'h080); put(2, 9'h001); put(3, 9'h108);
    put(4, 9'h14C); put(5, 9'h011); put(6, 9'h022); put(7, 0);
    put(8, 9'h011); put(9, 9'h033); put(10, 0); put(12, 0);
    run_prog("R9 clc", 8'h80, 5);

    // R7 unconditional jump skips code
    prog_start();
    put(0, 9'h047); put(1, 9'h011); put(2, 9'h099); put(3, 0);
    put(7, 9'h011); put(8, 9'h03C); put(9, 0);
    run_prog("R7 jmp", 8'h3C, 3);

    // R10 R2 invalid words halt with x0 untouched and state frozen
    foreach (bad_words[k]) begin
      prog_start();
      put(0, 9'h011); put(1, 9'h033); put(2, bad_words[k]);
      put(3, 9'h011); put(4, 9'h044); put(5, 0);
      run_prog($sformatf("R10 R2 invalid %03h", bad_words[k]), 8'h33, 2);
      repeat (10) @(negedge clk);
      chk("R10 frozen cycles", int'(cycle_count), 2);
      chk("R10 frozen x0", int'(x0_out), 8'h33);
    end

    // R2 priority: 0x1FF is a branch (jnz to 63), not an ALU op
    prog_start();
    put(0, 9'h011); put(1, 9'h033); put(2, 9'h1FF); put(3, 0); put(63, 0);
    run_prog("R2 priority cbr", 8'h33, 3);
    // R2 priority: 0x07F is a jump to 63, not invalid
    prog_start();
    put(0, 9'h011); put(1, 9'h033); put(2, 9'h07F); put(3, 0); put(63, 0);
    run_prog("R2 priority jmp", 8'h33, 3);

    // R5 R3 latched pass-X on x1 sees later ldi into x1
    prog_start();
    put(0, 9'h012); put(1, 9'h005); put(2, 9'h0D2); put(3, 9'h012);
    put(4, 9'h000); put(5, 9'h149); put(6, 9'h011); put(7, 9'h077);
    put(8, 0); put(9, 9'h094); put(10, 0);
    run_prog("R5 R3 latched select", 8'h05, 6);

    // R5 post-write recompute when destination is an operand
    prog_start();
    put(0, 9'h011); put(1, 9'h001); put(2, 9'h014); put(3, 9'h0FF);
    put(4, 9'h080); put(5, 9'h10C); put(6, 9'h14C); put(7, 0); put(12, 0);
    run_prog("R5 self-operand", 0, 6);

    // R3 R4 R6 sweep: op x1,y1 -> x0, then each of jz/jc/jnz/jnc
    for (int op = 0; op < 6; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          for (int v = 0; v < 4; v++) begin
            int r, cy, zf, fl, tk;
            r  = model_res(op, vals[ia], vals[ib]);
            cy = (op == 0 && (vals[ia] + vals[ib]) > 255) ? 1 : 0;
            zf = (r == 0) ? 1 : 0;
            fl = (v & 1) ? zf : cy;
            tk = fl ^ (v >> 1);
            prog_start();
            put(0, 9'h012); put(1, vals[ia]); put(2, 9'h018); put(3, vals[ib]);
            put(4, 9'h0E0 | (op << 2));
            put(5, 9'h100 | ((v >> 1) << 7) | ((v & 1) << 6) | 10);
            put(6, 9'h011); put(7, 9'h0AA); put(8, 0); put(10, 0);
            run_prog($sformatf("R3 R4 R6 op%0d a%02h b%02h v%0d", op, vals[ia], vals[ib], v),
                     tk ? r : 8'hAA, tk ? 5 : 6);
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule